// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a synthesizable model of a synchronous SRAM with no bus turnaround penalty. Every input (address, control, byte enables, chip enables and write data) is sampled on the rising clock edge. Write data trails its address, so a read can follow a write, or a write can follow a read, in the very next cycle. No idle cycle is needed to turn the data bus around.

A static mode input picks one of two timings. In pipelined mode, read data passes through an output register, and write data is taken two cycles after its address. In flow-through mode, read data comes straight out of the array in the cycle after the address edge, and write data is taken one cycle after its address. Because of this lag, a write can still be in flight when a read of the same word is issued. The core forwards that in-flight data lane by lane over the array contents.

An advance input continues a four-beat burst. The burst sequencer wraps inside the low two address bits, in linear or interleaved order. A sleep input stops new accesses from starting and keeps the array contents. An output-enable input gates the data outputs without waiting for a clock edge.

Top module: `sram_lw_core`

## Requirements
- R1: A cycle starts a new access only when `ce_a`=1, `ce_b_n`=0 and `ce_c`=1 while `adv`=0. Any other enable pattern with `adv`=0 is a deselect: a read produces no output beat and a write leaves the array unchanged.
- R2: With `pipe_mode`=1, a read whose address is sampled at edge k drives `dout_en`=1 and the read word on `dout` between edge k+1 and edge k+2.
- R3: With `pipe_mode`=0, a read whose address is sampled at edge k drives `dout_en`=1 and the read word between edge k and edge k+1.
- R4: With `pipe_mode`=1, the data for a write whose address is sampled at edge k is taken from `din` at edge k+2.
- R5: With `pipe_mode`=0, the data for a write whose address is sampled at edge k is taken from `din` at edge k+1.
- R6: Bytes are 9 bits wide. Byte i is bits 9i+8 down to 9i. A write changes byte i only when `bwe[i]`=1, and leaves the other bytes as they were.
- R7: A read returns every write issued before it, including writes whose data has not yet reached the array. It applies them in issue order, byte by byte, over the stored word. Reads and writes may alternate in consecutive cycles with no idle cycle.
- R8: With `adv`=1 after a read or write that was issued or continued in the previous cycle, the same operation continues at the next burst address. The upper address bits stay fixed, and `we`, the chip enables and `addr` are ignored. With `burst_lin`=1, the low two bits are (start + n) mod 4 for beat n. With `adv`=1 and no burst in progress, the cycle is a deselect.
- R9: With `burst_lin`=0, the low two address bits of beat n are start XOR n.
- R10: `oe`=0 forces `dout_en` to 0 at once, without waiting for a clock edge. Whenever `dout_en`=0, `dout` is zero.
- R11: With `sleep`=1, a cycle neither starts nor continues an access. Writes already issued still take their data, and the stored contents are kept.
- R12: After a clock edge with `rst`=1, `dout_en` is 0 and no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address of a new access |
| we | input | 1 | 1 = write, 0 = read, for a new access |
| adv | input | 1 | 1 = continue the current burst |
| bwe | input | NBYTES | Per-byte write enables, active high |
| ce_a | input | 1 | Chip enable, active high |
| ce_b_n | input | 1 | Chip enable, active low |
| ce_c | input | 1 | Chip enable, active high |
| oe | input | 1 | Asynchronous output enable, active high |
| burst_lin | input | 1 | Burst order: 1 = linear, 0 = interleaved (static) |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| sleep | input | 1 | Blocks new accesses when 1 |
| din | input | NBYTES*BYTE_W | Late write data |
| dout | output | NBYTES*BYTE_W | Read data, zero when not driven |
| dout_en | output | 1 | Output drivers enabled |

## Verification
The case that matters most is a read issued while an earlier write to the same word still has its data in flight. In the same clock edge, the array returns its stored word and a commit lands, and possibly a second write's data arrives on `din`. The bench provokes this with directed write-read-read sequences on one address using partial byte enables in both modes. It adds random traffic confined to 32 addresses, so that collisions recur inside bursts and across mode changes. Each output beat is judged against a reference memory. The reference applies every write at the edge where its data is due and computes the read word at the edge where the beat becomes visible.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low address bits of burst beat `beat` starting at `first`.
  function automatic logic [BURST_W-1:0] beat_offset(
    input logic [BURST_W-1:0] first,
    input logic [BURST_W-1:0] beat,
    input logic               linear
  );
    return linear ? first + beat : first ^ beat;
  endfunction

endpackage

// File: rtl/sram_lw_array.sv
module sram_lw_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  // One simple dual-port lane per byte, read-first on collision.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
      q <= mem[rd_addr];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/sram_lw_seq.sv
module sram_lw_seq
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              adv,
  input  logic              sel_ok,
  input  logic              sleep,
  input  logic              burst_lin,
  output op_e               nx_op,
  output logic [ADDR_W-1:0] nx_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q;
  op_e                op_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] first_q;
  logic [BURST_W-1:0] beat_q;

  logic               go_new;
  logic               go_cont;
  logic [HI_W-1:0]    hi_d;
  logic [BURST_W-1:0] first_d;
  logic [BURST_W-1:0] beat_d;

  always_comb begin
    go_cont = adv & act_q & ~sleep;
    go_new  = ~adv & sel_ok & ~sleep;
    hi_d    = go_new ? addr[ADDR_W-1:BURST_W] : hi_q;
    first_d = go_new ? addr[BURST_W-1:0] : first_q;
    beat_d  = go_cont ? beat_q + BURST_W'(1) : '0;
    if (go_cont)     nx_op = op_q;
    else if (go_new) nx_op = we ? OP_WR : OP_RD;
    else             nx_op = OP_NONE;
    nx_addr = {hi_d, beat_offset(first_d, beat_d, burst_lin)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      op_q    <= OP_NONE;
      hi_q    <= '0;
      first_q <= '0;
      beat_q  <= '0;
    end else begin
      act_q  <= go_new | go_cont;
      beat_q <= beat_d;
      if (go_new) begin
        op_q    <= we ? OP_WR : OP_RD;
        hi_q    <= hi_d;
        first_q <= first_d;
      end
    end
  end
endmodule

// File: rtl/sram_lw_merge.sv
module sram_lw_merge #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic [NBYTES*BYTE_W-1:0] base,
  input  logic [ADDR_W-1:0]        tgt_addr,
  input  logic                     old_v,
  input  logic [ADDR_W-1:0]        old_addr,
  input  logic [NBYTES-1:0]        old_be,
  input  logic [NBYTES*BYTE_W-1:0] old_data,
  input  logic                     new_v,
  input  logic [ADDR_W-1:0]        new_addr,
  input  logic [NBYTES-1:0]        new_be,
  input  logic [NBYTES*BYTE_W-1:0] new_data,
  output logic [NBYTES*BYTE_W-1:0] merged
);
  logic old_hit;
  logic new_hit;

  // Older in-flight write first, younger one overrides it lane by lane.
  always_comb begin
    old_hit = old_v && (old_addr == tgt_addr);
    new_hit = new_v && (new_addr == tgt_addr);
    merged  = base;
    for (int i = 0; i < NBYTES; i++) begin
      if (old_hit && old_be[i]) merged[i*BYTE_W +: BYTE_W] = old_data[i*BYTE_W +: BYTE_W];
      if (new_hit && new_be[i]) merged[i*BYTE_W +: BYTE_W] = new_data[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/sram_lw_core.sv
module sram_lw_core
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic                     adv,
  input  logic [NBYTES-1:0]        bwe,
  input  logic                     ce_a,
  input  logic                     ce_b_n,
  input  logic                     ce_c,
  input  logic                     oe,
  input  logic                     burst_lin,
  input  logic                     pipe_mode,
  input  logic                     sleep,
  input  logic [NBYTES*BYTE_W-1:0] din,
  output logic [NBYTES*BYTE_W-1:0] dout,
  output logic                     dout_en
);
  localparam int DATA_W = NBYTES * BYTE_W;

  logic              sel_ok;
  op_e               nx_op;
  logic [ADDR_W-1:0] nx_addr;

  // Issue stages: s1 = registered address, s2 = one cycle later.
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_be, s2_be;

  // Write whose data is on din at the coming edge.
  logic              cm_v;
  logic [ADDR_W-1:0] cm_addr;
  logic [NBYTES-1:0] cm_be;

  // Write committed at the last edge (array read missed it).
  logic              lc_v;
  logic [ADDR_W-1:0] lc_addr;
  logic [NBYTES-1:0] lc_be;
  logic [DATA_W-1:0] lc_data;

  logic [DATA_W-1:0] arr_q;
  logic [DATA_W-1:0] fwd_word;
  logic [DATA_W-1:0] out_q;
  logic              out_en_q;
  logic              rd_live;

  assign sel_ok = ce_a & ~ce_b_n & ce_c;

  sram_lw_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .we       (we),
    .adv      (adv),
    .sel_ok   (sel_ok),
    .sleep    (sleep),
    .burst_lin(burst_lin),
    .nx_op    (nx_op),
    .nx_addr  (nx_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op <= OP_NONE;
      s2_op <= OP_NONE;
    end else begin
      s1_op <= nx_op;
      s2_op <= s1_op;
    end
    s1_addr <= nx_addr;
    s1_be   <= bwe;
    s2_addr <= s1_addr;
    s2_be   <= s1_be;
  end

  always_comb begin
    if (pipe_mode) begin
      cm_v    = (s2_op == OP_WR);
      cm_addr = s2_addr;
      cm_be   = s2_be;
    end else begin
      cm_v    = (s1_op == OP_WR);
      cm_addr = s1_addr;
      cm_be   = s1_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lc_v <= 1'b0;
    else     lc_v <= cm_v;
    lc_addr <= cm_addr;
    lc_be   <= cm_be;
    lc_data <= din;
  end

  sram_lw_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_array (
    .clk    (clk),
    .wr_en  (cm_v),
    .wr_addr(cm_addr),
    .wr_be  (cm_be),
    .wr_data(din),
    .rd_addr(nx_addr),
    .rd_data(arr_q)
  );

  sram_lw_merge #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_merge (
    .base    (arr_q),
    .tgt_addr(s1_addr),
    .old_v   (lc_v),
    .old_addr(lc_addr),
    .old_be  (lc_be),
    .old_data(lc_data),
    .new_v   (pipe_mode & cm_v),
    .new_addr(cm_addr),
    .new_be  (cm_be),
    .new_data(din),
    .merged  (fwd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_en_q <= 1'b0;
      out_q    <= '0;
    end else begin
      out_en_q <= pipe_mode && (s1_op == OP_RD);
      out_q    <= fwd_word;
    end
  end

  assign rd_live = pipe_mode ? out_en_q : (s1_op == OP_RD);
  assign dout_en = rd_live & oe;
  assign dout    = dout_en ? (pipe_mode ? out_q : fwd_word) : '0;
endmodule

// File: rtl/sram_lw_checker.sv
module sram_lw_checker #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic          adv,
  input logic          ce_a,
  input logic          ce_b_n,
  input logic          ce_c,
  input logic          oe,
  input logic          pipe_mode,
  input logic          sleep,
  input logic [DW-1:0] dout,
  input logic          dout_en
);
  logic sel;
  logic new_rd;
  logic desel;

  assign sel    = ce_a & ~ce_b_n & ce_c;
  assign new_rd = ~adv & sel & ~sleep & ~we;
  assign desel  = ~adv & ~sel;

  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> !dout_en);

  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !oe |-> !dout_en);

  assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !dout_en |-> dout == '0);

  assert_flow_read_R3: assert property (@(posedge clk) disable iff (rst)
    !pipe_mode && !$past(pipe_mode) && oe && $past(new_rd) && !$past(rst) |-> dout_en);

  assert_pipe_read_R2: assert property (@(posedge clk) disable iff (rst)
    pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2) && oe
    && $past(new_rd, 2) && !$past(rst) && !$past(rst, 2) |-> dout_en);

  assert_flow_desel_R1: assert property (@(posedge clk) disable iff (rst)
    !pipe_mode && !$past(pipe_mode) && $past(desel) && !$past(rst) |-> !dout_en);

  assert_pipe_desel_R1: assert property (@(posedge clk) disable iff (rst)
    pipe_mode && $past(pipe_mode) && $past(pipe_mode, 2)
    && $past(desel, 2) && !$past(rst) && !$past(rst, 2) |-> !dout_en);

  assert_flow_sleep_R11: assert property (@(posedge clk) disable iff (rst)
    !pipe_mode && !$past(pipe_mode) && $past(sleep) && !$past(rst) |-> !dout_en);
endmodule

bind sram_lw_core sram_lw_checker #(.DW(NBYTES*BYTE_W)) i_checker (
  .clk      (clk),
  .rst      (rst),
  .we       (we),
  .adv      (adv),
  .ce_a     (ce_a),
  .ce_b_n   (ce_b_n),
  .ce_c     (ce_c),
  .oe       (oe),
  .pipe_mode(pipe_mode),
  .sleep    (sleep),
  .dout     (dout),
  .dout_en  (dout_en)
);

// File: tb/test_sram_lw_core.sv
module test_sram_lw_core;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int NBYTES = 2;
  localparam int BYTE_W = 9;
  localparam int DW     = NBYTES * BYTE_W;
  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int PQ     = 4;
  localparam logic [2:0] CE_ON = 3'b101; // {ce_a, ce_b_n, ce_c}

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0, adv = 1'b0, ce_a = 1'b0, ce_b_n = 1'b1, ce_c = 1'b0;
  logic oe = 1'b1, burst_lin = 1'b1, pipe_mode = 1'b0, sleep = 1'b0;
  logic [NBYTES-1:0] bwe = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lw_core #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_sram_lw_core (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .adv(adv), .bwe(bwe),
    .ce_a(ce_a), .ce_b_n(ce_b_n), .ce_c(ce_c), .oe(oe), .burst_lin(burst_lin),
    .pipe_mode(pipe_mode), .sleep(sleep), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int fails = 0;
  int edge_n = 0;
  string cur_req = "R12";

  logic [DW-1:0] ref_mem [DEPTH];
  bit b_act = 0;
  int b_op = 0, b_first = 0, b_beat = 0;
  logic [ADDR_W-1:0] b_base = '0;
  bit pw_v [PQ];
  logic [ADDR_W-1:0] pw_a [PQ];
  logic [NBYTES-1:0] pw_be [PQ];
  logic [DW-1:0] pw_d [PQ];
  int pw_due [PQ];
  bit pr_v [PQ];
  logic [ADDR_W-1:0] pr_a [PQ];
  int pr_show [PQ];
  bit exp_en = 0;
  logic [DW-1:0] exp_d = '0;

  function automatic logic [DW-1:0] put_bytes(logic [DW-1:0] old, logic [DW-1:0] nw, logic [NBYTES-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NBYTES; i++) if (be[i]) r[i*BYTE_W +: BYTE_W] = nw[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  function automatic int order_off(int first, int beat, bit lin);
    return lin ? (first + beat) % 4 : (first ^ beat);
  endfunction

  task automatic check(bit ok, string req, logic [DW:0] act, logic [DW:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model_edge();
    bit sel, cont, nw;
    int op;
    logic [ADDR_W-1:0] a;
    for (int i = 0; i < PQ; i++)
      if (pw_v[i] && pw_due[i] == edge_n) begin
        ref_mem[pw_a[i]] = put_bytes(ref_mem[pw_a[i]], din, pw_be[i]);
        pw_v[i] = 0;
      end
    sel  = ce_a && !ce_b_n && ce_c;
    cont = adv && b_act && !sleep;
    nw   = !adv && sel && !sleep;
    if (nw) begin
      b_op = we ? 2 : 1; b_base = addr; b_first = int'(addr[1:0]); b_beat = 0;
    end else if (cont) b_beat = (b_beat + 1) % 4;
    b_act = nw || cont;
    op = b_act ? b_op : 0;
    a = {b_base[ADDR_W-1:2], 2'(order_off(b_first, b_beat, burst_lin))};
    if (op == 2) begin
      for (int i = 0; i < PQ; i++) if (!pw_v[i]) begin
        pw_v[i] = 1; pw_a[i] = a; pw_be[i] = bwe; pw_d[i] = DW'($urandom);
        pw_due[i] = edge_n + (pipe_mode ? 2 : 1);
        break;
      end
    end else if (op == 1) begin
      for (int i = 0; i < PQ; i++) if (!pr_v[i]) begin
        pr_v[i] = 1; pr_a[i] = a; pr_show[i] = edge_n + (pipe_mode ? 1 : 0);
        break;
      end
    end
    exp_en = 0;
    for (int i = 0; i < PQ; i++)
      if (pr_v[i] && pr_show[i] == edge_n) begin
        exp_en = 1; exp_d = ref_mem[pr_a[i]]; pr_v[i] = 0;
      end
  endtask

  task automatic compare_out(string req);
    logic [DW:0] e;
    e = {exp_en & oe, (exp_en & oe) ? exp_d : DW'(0)};
    check({dout_en, dout} === e, req, {dout_en, dout}, e);
  endtask

  // One bus cycle: drive at the falling edge, sample one unit after the rising edge.
  task automatic step(bit s_we, bit s_adv, logic [2:0] s_ce, bit s_sleep,
                      logic [ADDR_W-1:0] s_a, logic [NBYTES-1:0] s_be, bit oe_probe);
    logic [DW-1:0] dn = DW'($urandom);
    for (int i = 0; i < PQ; i++) if (pw_v[i] && pw_due[i] == edge_n + 1) dn = pw_d[i];
    we = s_we; adv = s_adv; {ce_a, ce_b_n, ce_c} = s_ce; sleep = s_sleep;
    addr = s_a; bwe = s_be; din = dn;
    @(posedge clk);
    edge_n++;
    model_edge();
    #1;
    compare_out(cur_req);
    if (oe_probe && exp_en) begin
      oe = 1'b0; #1;
      check({dout_en, dout} === '0, "R10", {dout_en, dout}, '0);
      oe = 1'b1; #1;
      compare_out("R10");
    end
    @(negedge clk);
  endtask

  task automatic idle();                                         step(0, 0, 3'b000, 0, '0, '0, 0); endtask
  task automatic rd(logic [ADDR_W-1:0] a);                       step(0, 0, CE_ON, 0, a, '0, 0); endtask
  task automatic wr(logic [ADDR_W-1:0] a, logic [NBYTES-1:0] be); step(1, 0, CE_ON, 0, a, be, 0); endtask
  task automatic advance(logic [NBYTES-1:0] be);                 step(0, 1, 3'b000, 0, '0, be, 0); endtask

  task automatic set_mode(bit pm, bit lin);
    idle(); idle(); idle();
    pipe_mode = pm; burst_lin = lin;
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < PQ; i++) begin pw_v[i] = 0; pr_v[i] = 0; end
    // R12: reset state
    repeat (3) @(posedge clk);
    #1 check({dout_en, dout} === '0, "R12", {dout_en, dout}, '0);
    @(negedge clk); rst = 1'b0;
    cur_req = "R12"; idle();

    // R5: flow-through fill of the whole array
    cur_req = "R5";
    set_mode(0, 1);
    for (int i = 0; i < DEPTH; i++) wr(ADDR_W'(i), '1);
    idle(); idle();
    cur_req = "R3";
    for (int i = 0; i < 8; i++) rd(ADDR_W'(i * 7));

    // R4 / R2: pipelined writes then reads
    cur_req = "R4";
    set_mode(1, 1);
    for (int i = 0; i < 16; i++) wr(ADDR_W'(8'h40 + i), '1);
    cur_req = "R2";
    for (int i = 0; i < 16; i++) rd(ADDR_W'(8'h40 + i));
    idle(); idle();

    // R6 / R7: partial-byte writes and back-to-back forwarding, both modes
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 0, 1);
      cur_req = "R6";
      wr(8'h21, 2'b10); idle(); idle(); idle(); rd(8'h21); idle(); idle();
      cur_req = "R7";
      wr(8'h22, 2'b11); rd(8'h22); wr(8'h22, 2'b01); rd(8'h22);
      wr(8'h22, 2'b10); wr(8'h22, 2'b01); rd(8'h22); rd(8'h22);
      rd(8'h23); wr(8'h23, 2'b10); rd(8'h23); idle(); idle(); idle();
    end

    // R8 / R9: bursts in both orders, including wrap past four beats
    for (int m = 0; m < 4; m++) begin
      set_mode(m[0], m[1]);
      cur_req = m[1] ? "R8" : "R9";
      wr(8'h12, 2'b11); advance(2'b11); advance(2'b01); advance(2'b11);
      rd(8'h11); advance('0); advance('0); advance('0); advance('0);
      idle(); advance('0); idle(); idle(); idle();
    end

    // R1: deselect variants, and adv with no burst in progress
    set_mode(0, 1);
    cur_req = "R1";
    step(1, 0, 3'b100, 0, 8'h30, 2'b11, 0); idle(); rd(8'h30);
    step(1, 0, 3'b111, 0, 8'h31, 2'b11, 0); idle(); rd(8'h31);
    step(0, 0, 3'b001, 0, 8'h30, '0, 0); step(0, 0, 3'b111, 0, 8'h30, '0, 0);
    idle(); advance('0); idle();

    // R11: sleep blocks access, in-flight write still lands
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 1, 1);
      cur_req = "R11";
      wr(8'h50, 2'b11);
      step(1, 0, CE_ON, 1, 8'h51, 2'b11, 0);
      step(0, 0, CE_ON, 1, 8'h50, '0, 0);
      step(0, 1, CE_ON, 1, 8'h50, '0, 0);
      idle(); idle(); rd(8'h50); rd(8'h51); idle(); idle();
    end

    // R10: output enable overrides mid-cycle and across an edge
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 1, 1);
      cur_req = "R10";
      step(0, 0, CE_ON, 0, 8'h05, '0, 1);
      step(0, 0, CE_ON, 0, 8'h06, '0, 1);
      oe = 1'b0; rd(8'h07); rd(8'h08); oe = 1'b1;
      idle(); idle(); idle();
    end

    // Random mixed traffic over a small address window
    for (int blk = 0; blk < 6; blk++) begin
      set_mode(blk[0], ($urandom % 2) == 1);
      cur_req = pipe_mode ? "R2" : "R3";
      for (int n = 0; n < 500; n++) begin
        int r;
        logic [ADDR_W-1:0] ra;
        r  = $urandom % 10;
        ra = ADDR_W'($urandom % 32);
        if (r < 2)      idle();
        else if (r < 5) rd(ra);
        else if (r < 8) wr(ra, NBYTES'($urandom));
        else            advance(NBYTES'($urandom));
      end
    end
    idle(); idle(); idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule